// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the transmit and receive error counters of a CAN node and derives its fault-confinement state from them. The surrounding controller supplies single-cycle event pulses: a transmit error, a receive error, a successful transmit, a successful receive, and one pulse per sampled bit with its level. The block answers with the confinement state, both counter values and a set of condition flags. These flags are warning and passive for each direction, plus bus-off, and they are meant to drive an interrupt controller.

The counters move by fixed steps. A transmit error adds 8 and a receive error adds 1. A success removes 1 from its counter. The state register follows the counters one clock later. Once the node is in bus-off, counting stops. The node leaves bus-off only after it has watched 128 separate runs of 11 back-to-back recessive bits. Leaving bus-off clears both counters.

Top module: `can_fault_conf`

## Requirements
- R1: After reset the state output is error-active (code 0), both counters read 0 and every flag is low.
- R2: An error pulse adds 8 (transmit) or 1 (receive) to its counter. An ok pulse subtracts 1 and never takes a counter below 0. When an error pulse and an ok pulse for the same direction arrive in one cycle, only the error is applied.
- R3: The receive counter is 8 bits wide and holds at 255 instead of wrapping. The transmit counter is 9 bits wide, so values above 255 can be seen.
- R4: The warning flag of a direction is high exactly when its counter is 96 or more.
- R5: The passive flag of a direction is high exactly when its counter exceeds 127. One clock after either counter exceeds 127, the state becomes error-passive (code 1). It returns to error-active one clock after both counters are 127 or less.
- R6: One clock after the transmit counter exceeds 255, the state becomes bus-off (code 2) and the bus-off flag is raised. While in bus-off, error and ok pulses leave both counters unchanged.
- R7: In bus-off, a sampled bit (bit_valid high) with bit_recessive high extends the current recessive run. A dominant bit restarts the run but keeps the number of completed 11-bit runs. The clock edge that completes the 128th run clears both counters and returns the state to error-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err | input | 1 | Transmit error event pulse |
| rx_err | input | 1 | Receive error event pulse |
| tx_ok | input | 1 | Successful transmit pulse |
| rx_ok | input | 1 | Successful receive pulse |
| bit_valid | input | 1 | A bus bit was sampled this cycle |
| bit_recessive | input | 1 | Level of the sampled bit, 1 = recessive |
| state | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| tx_cnt | output | 9 | Transmit error counter |
| rx_cnt | output | 8 | Receive error counter |
| tx_warn | output | 1 | Transmit counter at 96 or above |
| rx_warn | output | 1 | Receive counter at 96 or above |
| tx_passive | output | 1 | Transmit counter above 127 |
| rx_passive | output | 1 | Receive counter above 127 |
| bus_off | output | 1 | Node is in bus-off |

## Verification
The hardest situation to reach is the last bit of bus-off recovery. It needs the transmit counter pushed through passive and past 255, followed by more than 1400 sampled bits. The stimulus first sends 17 transmit errors from 127. It then feeds 127 complete recessive runs. Next it sends a partial run that is broken by a dominant bit, so the completed-run count has to survive the restart. Finally it sends 11 more recessive bits. The check confirms that exit happens on exactly the last of those bits and not one bit earlier.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      ST_ACTIVE  = 2'd0,
      ST_PASSIVE = 2'd1,
      ST_BUSOFF  = 2'd2
   } fc_state_t;
endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
   parameter int W    = 8,
   parameter int STEP = 1,
   parameter bit SAT  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         hold,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt
);
   localparam logic [W:0] STEP_V = (W+1)'(STEP);
   localparam logic [W:0] MAX_V  = {1'b0, {W{1'b1}}};

   if (W < 2) begin : g_bad_w
      $error("can_fc_counter: W must be at least 2");
   end
   if (STEP < 1 || STEP >= (1 << W)) begin : g_bad_step
      $error("can_fc_counter: STEP out of range");
   end

   logic [W:0]   sum;
   logic [W-1:0] inc_val;
   logic [W-1:0] nxt;

   assign sum = {1'b0, cnt} + STEP_V;

   if (SAT) begin : g_sat
      assign inc_val = (sum > MAX_V) ? MAX_V[W-1:0] : sum[W-1:0];
   end else begin : g_wrap
      assign inc_val = sum[W-1:0];
   end

   always_comb begin
      nxt = cnt;
      if (clr)                       nxt = '0;
      else if (hold)                 nxt = cnt;
      else if (inc)                  nxt = inc_val;
      else if (dec && cnt != '0)     nxt = cnt - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
   parameter int RUN_LEN = 11,
   parameter int RUN_CNT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic bit_valid,
   input  logic bit_recessive,
   output logic done
);
   localparam int RW = $clog2(RUN_LEN + 1);
   localparam int OW = $clog2(RUN_CNT + 1);
   localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
   localparam logic [OW-1:0] OCC_LAST = OW'(RUN_CNT - 1);

   if (RUN_LEN < 2 || RUN_CNT < 1) begin : g_bad_cfg
      $error("can_fc_recovery: run length or run count too small");
   end

   logic [RW-1:0] run_q;
   logic [OW-1:0] occ_q;
   logic          run_end;

   assign run_end = arm && bit_valid && bit_recessive && (run_q == RUN_LAST);
   assign done    = run_end && (occ_q == OCC_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !arm) begin
         run_q <= '0;
         occ_q <= '0;
      end else if (bit_valid) begin
         if (!bit_recessive) begin
            run_q <= '0;
         end else if (run_end) begin
            run_q <= '0;
            occ_q <= occ_q + 1'b1;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import can_fc_pkg::*;
#(
   parameter int RX_W      = 8,
   parameter int TX_STEP   = 8,
   parameter int RX_STEP   = 1,
   parameter int WARN_LVL  = 96,
   parameter int PASS_LVL  = 127,
   parameter int RUN_LEN   = 11,
   parameter int RUN_CNT   = 128,
   localparam int TX_W     = RX_W + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tx_err,
   input  logic            rx_err,
   input  logic            tx_ok,
   input  logic            rx_ok,
   input  logic            bit_valid,
   input  logic            bit_recessive,
   output logic [1:0]      state,
   output logic [TX_W-1:0] tx_cnt,
   output logic [RX_W-1:0] rx_cnt,
   output logic            tx_warn,
   output logic            rx_warn,
   output logic            tx_passive,
   output logic            rx_passive,
   output logic            bus_off
);
   localparam logic [TX_W-1:0] TX_WARN = TX_W'(WARN_LVL);
   localparam logic [RX_W-1:0] RX_WARN = RX_W'(WARN_LVL);
   localparam logic [TX_W-1:0] TX_PASS = TX_W'(PASS_LVL);
   localparam logic [RX_W-1:0] RX_PASS = RX_W'(PASS_LVL);
   localparam logic [TX_W-1:0] TX_OFF  = TX_W'((1 << RX_W) - 1);

   if (WARN_LVL > PASS_LVL || PASS_LVL >= (1 << RX_W) - 1) begin : g_bad_lvl
      $error("can_fault_conf: thresholds out of order");
   end

   fc_state_t st_q, st_d;
   logic      in_off;
   logic      rec_done;

   assign in_off = (st_q == ST_BUSOFF);

   can_fc_counter #(.W(TX_W), .STEP(TX_STEP), .SAT(1'b1)) u_txc (
      .clk(clk), .rst_n(rst_n), .clr(rec_done), .hold(in_off),
      .inc(tx_err), .dec(tx_ok), .cnt(tx_cnt)
   );

   can_fc_counter #(.W(RX_W), .STEP(RX_STEP), .SAT(1'b1)) u_rxc (
      .clk(clk), .rst_n(rst_n), .clr(rec_done), .hold(in_off),
      .inc(rx_err), .dec(rx_ok), .cnt(rx_cnt)
   );

   can_fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_CNT(RUN_CNT)) u_rec (
      .clk(clk), .rst_n(rst_n), .arm(in_off), .bit_valid(bit_valid),
      .bit_recessive(bit_recessive), .done(rec_done)
   );

   always_comb begin
      st_d = st_q;
      if (in_off) begin
         if (rec_done) st_d = ST_ACTIVE;
      end else if (tx_cnt > TX_OFF) begin
         st_d = ST_BUSOFF;
      end else if (tx_cnt > TX_PASS || rx_cnt > RX_PASS) begin
         st_d = ST_PASSIVE;
      end else begin
         st_d = ST_ACTIVE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_ACTIVE;
      else        st_q <= st_d;
   end

   assign state      = st_q;
   assign bus_off    = in_off;
   assign tx_warn    = (tx_cnt >= TX_WARN);
   assign rx_warn    = (rx_cnt >= RX_WARN);
   assign tx_passive = (tx_cnt > TX_PASS);
   assign rx_passive = (rx_cnt > RX_PASS);
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
   parameter int RX_W = 8,
   localparam int TX_W = RX_W + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tx_err,
   input logic            rx_err,
   input logic            tx_ok,
   input logic            rx_ok,
   input logic            bit_valid,
   input logic [1:0]      state,
   input logic [TX_W-1:0] tx_cnt,
   input logic [RX_W-1:0] rx_cnt,
   input logic            bus_off
);
   AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'd3); // R5

   AST_RX_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == {RX_W{1'b1}} && rx_err && !bus_off) |=> rx_cnt == {RX_W{1'b1}}); // R3

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == '0 && rx_ok && !rx_err && !bus_off) |=> rx_cnt == '0); // R2

   AST_PASSIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && rx_cnt > RX_W'(127)) |=> state == 2'd1); // R5

   AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off && !bit_valid) |=> (bus_off && $stable(tx_cnt) && $stable(rx_cnt))); // R6

   AST_EXIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_off) |-> (tx_cnt == '0 && rx_cnt == '0 && state == 2'd0)); // R7
endmodule

bind can_fault_conf can_fault_conf_chk #(.RX_W(RX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
   .tx_ok(tx_ok), .rx_ok(rx_ok), .bit_valid(bit_valid), .state(state),
   .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .bus_off(bus_off)
);

// File: tb/can_fault_conf_bench.sv
module can_fault_conf_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0;
   logic       bit_valid = 1'b0, bit_recessive = 1'b0;
   logic [1:0] state;
   logic [8:0] tx_cnt;
   logic [7:0] rx_cnt;
   logic       tx_warn, rx_warn, tx_passive, rx_passive, bus_off;
   int         n_chk = 0;
   int         n_bad = 0;

   always #5 clk = ~clk;

   can_fault_conf u_can_fault_conf (
      .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
      .tx_ok(tx_ok), .rx_ok(rx_ok), .bit_valid(bit_valid),
      .bit_recessive(bit_recessive), .state(state), .tx_cnt(tx_cnt),
      .rx_cnt(rx_cnt), .tx_warn(tx_warn), .rx_warn(rx_warn),
      .tx_passive(tx_passive), .rx_passive(rx_passive), .bus_off(bus_off)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one pulse, then one idle cycle so the state register catches up
   task automatic ev(input logic te, input logic re, input logic to, input logic ro, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro;
      end
      @(negedge clk);
      tx_err = 1'b0; rx_err = 1'b0; tx_ok = 1'b0; rx_ok = 1'b0;
      @(negedge clk);
   endtask

   task automatic bits(input logic rec, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_valid = 1'b1; bit_recessive = rec;
      end
      @(negedge clk);
      bit_valid = 1'b0; bit_recessive = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 state", state, 0);
      chk("R1 tx_cnt", tx_cnt, 0);
      chk("R1 rx_cnt", rx_cnt, 0);
      chk("R1 flags", {tx_warn, rx_warn, tx_passive, rx_passive, bus_off}, 0);
   endtask

   task automatic t_steps();
      do_reset();
      ev(1, 0, 1, 0, 1);
      chk("R2 tx error wins over ok", tx_cnt, 8);
      ev(0, 1, 0, 0, 3);
      chk("R2 rx +1 each", rx_cnt, 3);
      ev(0, 0, 0, 1, 1);
      chk("R2 rx -1", rx_cnt, 2);
      ev(0, 0, 0, 1, 3);
      chk("R2 rx floor at 0", rx_cnt, 0);
      ev(0, 0, 1, 0, 1);
      chk("R2 tx -1", tx_cnt, 7);
   endtask

   task automatic t_rx_path();
      do_reset();
      ev(0, 1, 0, 0, 95);
      chk("R4 rx_warn low at 95", rx_warn, 0);
      ev(0, 1, 0, 0, 1);
      chk("R4 rx_warn high at 96", rx_warn, 1);
      ev(0, 1, 0, 0, 31);
      chk("R5 rx_passive low at 127", rx_passive, 0);
      chk("R5 state active at 127", state, 0);
      ev(0, 1, 0, 0, 1);
      chk("R5 rx_passive at 128", rx_passive, 1);
      chk("R5 state passive", state, 1);
      ev(0, 0, 0, 1, 1);
      chk("R5 back to active", state, 0);
      ev(0, 1, 0, 0, 200);
      chk("R3 rx saturates", rx_cnt, 255);
      chk("R3 still passive, not bus-off", state, 1);
   endtask

   task automatic t_tx_and_recovery();
      do_reset();
      ev(1, 0, 0, 0, 11);
      chk("R4 tx_warn low at 88", tx_warn, 0);
      ev(1, 0, 0, 0, 1);
      chk("R4 tx_warn high at 96", tx_warn, 1);
      ev(1, 0, 0, 0, 4);
      chk("R5 tx_passive at 128", tx_passive, 1);
      chk("R5 state passive from tx", state, 1);
      ev(0, 0, 1, 0, 1);
      chk("R5 active at tx 127", state, 0);
      ev(1, 0, 0, 0, 16);
      chk("R6 tx 255 not bus-off", state, 1);
      ev(1, 0, 0, 0, 1);
      chk("R3 tx counter above 255", tx_cnt, 263);
      chk("R6 bus-off state", state, 2);
      chk("R6 bus_off flag", bus_off, 1);
      ev(1, 1, 1, 1, 3);
      chk("R6 tx frozen", tx_cnt, 263);
      chk("R6 rx frozen", rx_cnt, 0);
      bits(1, 127 * 11);
      bits(1, 10);
      bits(0, 1);
      bits(1, 10);
      chk("R7 restarted run keeps bus-off", bus_off, 1);
      bits(1, 1);
      chk("R7 exit to active", state, 0);
      chk("R7 tx cleared", tx_cnt, 0);
      chk("R7 rx cleared", rx_cnt, 0);
   endtask

   initial begin
      t_reset();
      t_steps();
      t_rx_path();
      t_tx_and_recovery();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule